// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block takes raw address-match flags from a bank of instruction breakpoint comparators and a bank of data watchpoint comparators and decides whether any of them should actually raise a debug event. Address comparison happens elsewhere. Here each raised flag is filtered by the comparator's control word against the current processor context: the security state, the privilege level, and an optional link to a context-ID breakpoint. The filtering only takes effect when global debug is enabled and debug exceptions are currently permitted.

Each request carries a full snapshot of the context and selects one bank, breakpoints or watchpoints. The block answers one cycle later with a fired flag, the index of the lowest-numbered qualifying comparator, and the fault-status code to report. Requests use a valid/ready pair and responses use a valid/ready pair. The response register is the only storage. It accepts a new request whenever it is empty or its current response is being taken in the same cycle. Otherwise the request stalls and the response holds steady.

Top module: `dbg_hit_qual`

## Requirements
- R1: The security field of a control word, bits 15:14, limits where the comparator can qualify. A value of 0 qualifies in either state. A value of 1 or 3 qualifies only when `req_secure` is 0. A value of 2 qualifies only when `req_secure` is 1.
- R2: The privilege checks use the access level. At levels 2 and 3, control bit 13 must be 1. At level 1, control bit 1 must be 1. At level 0, control bit 2 must be 1.
- R3: When `req_is_wp` is 1 and `req_unpriv` is 1, the privilege check is made as if the access level were 0. On breakpoint requests, `req_unpriv` has no effect.
- R4: When the linked flag, control bit 20, is 1, the comparator qualifies only if all of the following hold for its link number L, bits 19:16:
  - L lies between `bp_last - ctx_last` and `bp_last` inclusive.
  - L is below the breakpoint count.
  - Bit 0 of the linked breakpoint's control word is 1.
- R5: A linked comparator also qualifies only if all of the following hold for the linked breakpoint:
  - Its type field, bits 23:20, equals 3.
  - The current level `req_el` is 0 or 1.
  - `ctx_id` equals the breakpoint's value word.
- R6: No comparator fires unless bit 15 of `mon_ctl` is 1 and `dbg_excp_ok` is 1.
- R7: A comparator qualifies only when its raw hit flag is 1. `rsp_fired` is the OR of all qualifying comparators in the selected bank, and `rsp_idx` is the lowest qualifying index.
- R8: When the response fires, `rsp_fsc` is 0x222 if `long_desc` is 1 and 0x002 if it is 0. When the response does not fire, both `rsp_fsc` and `rsp_idx` are 0.
- R9: A request accepted at a clock edge produces its response at that same edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields do not change.
- R10: While reset is asserted, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_wp | input | 1 | 1 selects the watchpoint bank, 0 the breakpoint bank |
| req_el | input | 2 | Current privilege level |
| req_secure | input | 1 | Current security state (1 = secure) |
| req_unpriv | input | 1 | Data access flagged as unprivileged |
| mon_ctl | input | 32 | Monitor debug control word; bit 15 is the global enable |
| dbg_excp_ok | input | 1 | Debug exceptions permitted |
| long_desc | input | 1 | Long-descriptor fault format selected |
| bp_last | input | 4 | Highest implemented breakpoint number |
| ctx_last | input | 4 | Context-aware breakpoint span used for the lower link bound |
| bp_hit | input | NBP | Raw breakpoint address hits |
| wp_hit | input | NWP | Raw watchpoint address hits |
| bp_ctl | input | NBP x 32 | Breakpoint control words |
| wp_ctl | input | NWP x 32 | Watchpoint control words |
| bp_val | input | NBP x 32 | Breakpoint value words, compared against the context ID |
| ctx_id | input | 32 | Current context ID |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fired | output | 1 | A comparator qualified |
| rsp_idx | output | IW | Lowest qualifying comparator index |
| rsp_fsc | output | 10 | Fault-status code |

## Verification
The assertions assume that `rsp_ready` and `req_valid` are known at every clock edge after reset, and that the consumer's hold rule depends only on `rsp_ready`. The stimulus therefore drives every input at the falling edge from known values, and keeps `req_valid` low during reset. Random control words are biased so that security, privilege and link outcomes all occur, including link numbers beyond the implemented count and a `bp_last` above the bank size. Directed cases cover each security encoding, each privilege level, the unprivileged remap, both link bounds, a disabled or wrongly typed linked entry, the global gate, priority between two hits, and a stalled response.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int CTL_W      = 32;
  localparam int FSC_W      = 10;
  localparam int B_EN       = 0;
  localparam int B_PRV_L1   = 1;
  localparam int B_PRV_L0   = 2;
  localparam int B_HIGH     = 13;
  localparam int B_SEC_LO   = 14;
  localparam int B_LNK_LO   = 16;
  localparam int B_LINKED   = 20;
  localparam int B_TYPE_LO  = 20;
  localparam logic [3:0] TYPE_CTX = 4'd3;
  localparam logic [FSC_W-1:0] FSC_LONG  = 10'h222;
  localparam logic [FSC_W-1:0] FSC_SHORT = 10'h002;

  typedef enum logic [1:0] {
    SEC_ANY  = 2'd0,
    SEC_NS_A = 2'd1,
    SEC_ONLY = 2'd2,
    SEC_NS_B = 2'd3
  } sec_sel_e;
endpackage

// File: rtl/dbq_link.sv
module dbq_link
  import dbq_pkg::*;
#(
  parameter int NBP = 6
) (
  input  logic                      linked,
  input  logic [3:0]                lnk,
  input  logic [NBP-1:0][CTL_W-1:0] bp_ctl,
  input  logic [NBP-1:0][31:0]      bp_val,
  input  logic [3:0]                bp_last,
  input  logic [3:0]                ctx_last,
  input  logic [31:0]               ctx_id,
  input  logic [1:0]                cur_el,
  output logic                      ok
);
  logic signed [5:0] lo_bound;
  logic              in_range;
  logic [CTL_W-1:0]  sel_ctl;
  logic [31:0]       sel_val;

  assign lo_bound = $signed({2'b00, bp_last}) - $signed({2'b00, ctx_last});
  assign in_range = ($signed({2'b00, lnk}) >= lo_bound) && (lnk <= bp_last)
                    && ({28'd0, lnk} < NBP);

  always_comb begin
    sel_ctl = '0;
    sel_val = '0;
    for (int i = 0; i < NBP; i++) begin
      if (lnk == 4'(i)) begin
        sel_ctl = bp_ctl[i];
        sel_val = bp_val[i];
      end
    end
  end

  assign ok = !linked ||
              (in_range && sel_ctl[B_EN] &&
               sel_ctl[B_TYPE_LO +: 4] == TYPE_CTX &&
               cur_el <= 2'd1 && ctx_id == sel_val);
endmodule

// File: rtl/dbq_slot.sv
module dbq_slot
  import dbq_pkg::*;
(
  input  logic             hit,
  input  logic [CTL_W-1:0] ctl,
  input  logic             secure,
  input  logic [1:0]       acc_el,
  input  logic             link_ok,
  output logic             q
);
  logic sec_ok;
  logic prv_ok;

  always_comb begin
    unique case (sec_sel_e'(ctl[B_SEC_LO +: 2]))
      SEC_ANY:            sec_ok = 1'b1;
      SEC_ONLY:           sec_ok = secure;
      SEC_NS_A, SEC_NS_B: sec_ok = !secure;
      default:            sec_ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (acc_el)
      2'd0:    prv_ok = ctl[B_PRV_L0];
      2'd1:    prv_ok = ctl[B_PRV_L1];
      default: prv_ok = ctl[B_HIGH];
    endcase
  end

  assign q = hit && sec_ok && prv_ok && link_ok;
endmodule

// File: rtl/dbq_pick.sv
module dbq_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  q,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (q[i]) idx = IW'(i);
    end
  end
  assign any = |q;
endmodule

// File: rtl/dbg_hit_qual.sv
module dbg_hit_qual
  import dbq_pkg::*;
#(
  parameter int NBP = 6,
  parameter int NWP = 4,
  localparam int NMAX = (NBP > NWP) ? NBP : NWP,
  localparam int IW   = (NMAX > 1) ? $clog2(NMAX) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_is_wp,
  input  logic [1:0]                req_el,
  input  logic                      req_secure,
  input  logic                      req_unpriv,
  input  logic [31:0]               mon_ctl,
  input  logic                      dbg_excp_ok,
  input  logic                      long_desc,
  input  logic [3:0]                bp_last,
  input  logic [3:0]                ctx_last,
  input  logic [NBP-1:0]            bp_hit,
  input  logic [NWP-1:0]            wp_hit,
  input  logic [NBP-1:0][CTL_W-1:0] bp_ctl,
  input  logic [NWP-1:0][CTL_W-1:0] wp_ctl,
  input  logic [NBP-1:0][31:0]      bp_val,
  input  logic [31:0]               ctx_id,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic                      rsp_fired,
  output logic [IW-1:0]             rsp_idx,
  output logic [FSC_W-1:0]          rsp_fsc
);
  logic [NBP-1:0] bp_q;
  logic [NWP-1:0] wp_q;
  logic           bp_any, wp_any, gate, fire_n;
  logic [IW-1:0]  bp_idx, wp_idx, idx_n;
  logic [1:0]     wp_el;
  logic           take;

  assign wp_el = req_unpriv ? 2'd0 : req_el;

  for (genvar b = 0; b < NBP; b++) begin : g_bp
    logic lok;
    dbq_link #(.NBP(NBP)) u_lnk (
      .linked(bp_ctl[b][B_LINKED]), .lnk(bp_ctl[b][B_LNK_LO +: 4]),
      .bp_ctl(bp_ctl), .bp_val(bp_val), .bp_last(bp_last),
      .ctx_last(ctx_last), .ctx_id(ctx_id), .cur_el(req_el), .ok(lok));
    dbq_slot u_slot (
      .hit(bp_hit[b]), .ctl(bp_ctl[b]), .secure(req_secure),
      .acc_el(req_el), .link_ok(lok), .q(bp_q[b]));
  end

  for (genvar w = 0; w < NWP; w++) begin : g_wp
    logic lok;
    dbq_link #(.NBP(NBP)) u_lnk (
      .linked(wp_ctl[w][B_LINKED]), .lnk(wp_ctl[w][B_LNK_LO +: 4]),
      .bp_ctl(bp_ctl), .bp_val(bp_val), .bp_last(bp_last),
      .ctx_last(ctx_last), .ctx_id(ctx_id), .cur_el(req_el), .ok(lok));
    dbq_slot u_slot (
      .hit(wp_hit[w]), .ctl(wp_ctl[w]), .secure(req_secure),
      .acc_el(wp_el), .link_ok(lok), .q(wp_q[w]));
  end

  dbq_pick #(.N(NBP), .IW(IW)) u_pick_bp (.q(bp_q), .any(bp_any), .idx(bp_idx));
  dbq_pick #(.N(NWP), .IW(IW)) u_pick_wp (.q(wp_q), .any(wp_any), .idx(wp_idx));

  assign gate   = mon_ctl[15] && dbg_excp_ok;
  assign fire_n = gate && (req_is_wp ? wp_any : bp_any);
  assign idx_n  = fire_n ? (req_is_wp ? wp_idx : bp_idx) : '0;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fired <= 1'b0;
      rsp_idx   <= '0;
      rsp_fsc   <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_fired <= fire_n;
      rsp_idx   <= idx_n;
      rsp_fsc   <= fire_n ? (long_desc ? FSC_LONG : FSC_SHORT) : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled response holds its fields
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fired) &&
                                $stable(rsp_idx) && $stable(rsp_fsc));

  // R9: an empty response slot always accepts
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R8: fault code takes one of two values when fired, zero otherwise
  p_fsc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fired ? (rsp_fsc == FSC_LONG || rsp_fsc == FSC_SHORT)
                             : (rsp_fsc == '0 && rsp_idx == '0)));

  // R6: a request taken with the gate closed never fires
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take) && !$past(gate) |-> !rsp_fired);

  // R10: reset empties the response slot
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);
endmodule

// File: tb/sim_dbg_hit_qual.sv
module sim_dbg_hit_qual;
  localparam int CLK_NS = 10;
  localparam int NBP = 6;
  localparam int NWP = 4;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_wp = 1'b0, req_secure = 1'b0, req_unpriv = 1'b0;
  logic [1:0] req_el = '0;
  logic [31:0] mon_ctl = '0;
  logic dbg_excp_ok = 1'b0, long_desc = 1'b0, rsp_ready = 1'b1;
  logic [3:0] bp_last = '0, ctx_last = '0;
  logic [NBP-1:0] bp_hit = '0;
  logic [NWP-1:0] wp_hit = '0;
  logic [NBP-1:0][31:0] bp_ctl = '0;
  logic [NWP-1:0][31:0] wp_ctl = '0;
  logic [NBP-1:0][31:0] bp_val = '0;
  logic [31:0] ctx_id = '0;
  logic req_ready, rsp_valid, rsp_fired;
  logic [IW-1:0] rsp_idx;
  logic [9:0] rsp_fsc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  dbg_hit_qual #(.NBP(NBP), .NWP(NWP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_wp(req_is_wp), .req_el(req_el), .req_secure(req_secure),
    .req_unpriv(req_unpriv), .mon_ctl(mon_ctl), .dbg_excp_ok(dbg_excp_ok),
    .long_desc(long_desc), .bp_last(bp_last), .ctx_last(ctx_last),
    .bp_hit(bp_hit), .wp_hit(wp_hit), .bp_ctl(bp_ctl), .wp_ctl(wp_ctl),
    .bp_val(bp_val), .ctx_id(ctx_id), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fired(rsp_fired), .rsp_idx(rsp_idx),
    .rsp_fsc(rsp_fsc));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit slot_ok(logic [31:0] c, bit hit, bit is_wp);
    int acc = (is_wp && req_unpriv) ? 0 : int'(req_el);
    int l;
    if (!hit) return 0;
    if ((c[15:14] == 2'd1 || c[15:14] == 2'd3) && req_secure) return 0;
    if (c[15:14] == 2'd2 && !req_secure) return 0;
    if (acc >= 2 && !c[13]) return 0;
    if (acc == 1 && !c[1]) return 0;
    if (acc == 0 && !c[2]) return 0;
    if (c[20]) begin
      l = int'(c[19:16]);
      if (l > int'(bp_last) || l < int'(bp_last) - int'(ctx_last) || l >= NBP) return 0;
      if (!bp_ctl[l][0] || bp_ctl[l][23:20] != 4'd3) return 0;
      if (req_el > 2'd1 || ctx_id != bp_val[l]) return 0;
    end
    return 1;
  endfunction

  task automatic expect_of(output bit f, output int ix, output logic [9:0] fs);
    f = 0; ix = 0; fs = '0;
    if (!(mon_ctl[15] && dbg_excp_ok)) return;
    if (req_is_wp) begin
      for (int i = NWP - 1; i >= 0; i--)
        if (slot_ok(wp_ctl[i], wp_hit[i], 1)) begin f = 1; ix = i; end
    end else begin
      for (int i = NBP - 1; i >= 0; i--)
        if (slot_ok(bp_ctl[i], bp_hit[i], 0)) begin f = 1; ix = i; end
    end
    if (f) fs = long_desc ? 10'h222 : 10'h002;
  endtask

  // drive at negedge (already there), accept at posedge, check at next negedge
  task automatic step(string tag, int want);
    bit f; int ix; logic [9:0] fs;
    expect_of(f, ix, fs);
    req_valid = 1'b1;
    @(negedge clk);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fired"}, 32'(rsp_fired), 32'(f));
    chk({tag, " idx"}, 32'(rsp_idx), 32'(ix));
    chk({tag, " fsc"}, 32'(rsp_fsc), 32'(fs));
    if (want >= 0) chk({tag, " directed"}, 32'(rsp_fired), 32'(want));
  endtask

  task automatic clean();
    bp_hit = '0; wp_hit = '0; bp_ctl = '0; wp_ctl = '0; bp_val = '0;
    req_is_wp = 0; req_el = 2'd1; req_secure = 0; req_unpriv = 0;
    mon_ctl = 32'h8000; dbg_excp_ok = 1; long_desc = 0;
    bp_last = 4'd5; ctx_last = 4'd1; ctx_id = 32'hCAFE_0001;
  endtask

  initial begin
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 security field
    clean(); bp_hit[0] = 1; bp_ctl[0] = 32'h0000_0002;
    step("R1 any/ns", 1);
    req_secure = 1; step("R1 any/s", 1);
    bp_ctl[0][15:14] = 2'd1; step("R1 ns-only in secure", 0);
    bp_ctl[0][15:14] = 2'd3; step("R1 ns-only(3) in secure", 0);
    bp_ctl[0][15:14] = 2'd2; step("R1 s-only in secure", 1);
    req_secure = 0; step("R1 s-only in ns", 0);

    // R2 privilege
    clean(); bp_hit[1] = 1; bp_ctl[1] = 32'h0000_0004;
    req_el = 0; step("R2 el0 bit2", 1);
    req_el = 1; step("R2 el1 needs bit1", 0);
    req_el = 2; step("R2 el2 needs bit13", 0);
    bp_ctl[1][13] = 1; req_el = 3; step("R2 el3 bit13", 1);

    // R3 unprivileged remap
    clean(); wp_hit[2] = 1; wp_ctl[2] = 32'h0000_0004;
    req_is_wp = 1; req_el = 1; step("R3 wp el1 no remap", 0);
    req_unpriv = 1; step("R3 wp unpriv as el0", 1);
    req_is_wp = 0; bp_hit[2] = 1; bp_ctl[2] = 32'h0000_0004;
    step("R3 bp ignores unpriv", 0);

    // R4/R5 linked
    clean(); bp_ctl[4] = 32'h0030_0001; bp_val[4] = ctx_id;
    bp_ctl[5] = 32'h0030_0001; bp_val[5] = ctx_id;
    bp_ctl[3] = 32'h0030_0001; bp_val[3] = ctx_id;
    wp_hit[0] = 1; req_is_wp = 1;
    wp_ctl[0] = 32'h0014_0002; step("R4 link low bound 4", 1);
    wp_ctl[0] = 32'h0015_0002; step("R4 link high bound 5", 1);
    wp_ctl[0] = 32'h0013_0002; step("R4 link below range", 0);
    bp_last = 4'd7; ctx_last = 4'd1;
    wp_ctl[0] = 32'h0017_0002; step("R4 link beyond bank", 0);
    clean(); bp_ctl[4] = 32'h0030_0000; bp_val[4] = ctx_id;
    wp_hit[0] = 1; req_is_wp = 1; wp_ctl[0] = 32'h0014_0002;
    step("R4 linked entry disabled", 0);
    bp_ctl[4] = 32'h0050_0001; step("R5 wrong type", 0);
    bp_ctl[4] = 32'h0030_0001; bp_val[4] = ~ctx_id; step("R5 ctx mismatch", 0);
    bp_val[4] = ctx_id; wp_ctl[0][13] = 1; req_el = 2; step("R5 el2 no ctx match", 0);
    req_el = 1; step("R5 ctx match", 1);

    // R6 gate
    clean(); bp_hit[0] = 1; bp_ctl[0] = 32'h2;
    mon_ctl = 32'h0; step("R6 global off", 0);
    mon_ctl = 32'h8000; dbg_excp_ok = 0; step("R6 excp blocked", 0);

    // R7/R8 priority and code
    clean(); bp_hit = 6'b101100; bp_ctl[2] = 32'h0; bp_ctl[3] = 32'h2; bp_ctl[5] = 32'h2;
    step("R7 lowest qualifying idx3", 1);
    chk("R7 idx", 32'(rsp_idx), 32'd3);
    long_desc = 1; step("R8 long fsc", 1);
    chk("R8 fsc long", 32'(rsp_fsc), 32'h222);
    bp_hit = '0; step("R8 no fire zero", 0);
    chk("R8 fsc zero", 32'(rsp_fsc), 32'h0);

    // R9 stall
    clean(); bp_hit[0] = 1; bp_ctl[0] = 32'h2;
    step("R9 pre", 1);
    rsp_ready = 0; bp_hit = '0;
    @(negedge clk);
    chk("R9 ready low while stalled", 32'(req_ready), 32'd0);
    chk("R9 held fired", 32'(rsp_fired), 32'd1);
    rsp_ready = 1;
    step("R9 after release", 0);

    // random
    for (int k = 0; k < 400; k++) begin
      req_is_wp = 1'($urandom); req_el = 2'($urandom); req_secure = 1'($urandom);
      req_unpriv = 1'($urandom);
      mon_ctl = ($urandom % 8 != 0) ? 32'h8000 : 32'h0;
      dbg_excp_ok = ($urandom % 8 != 0); long_desc = 1'($urandom);
      bp_last = 4'($urandom % 8); ctx_last = 4'($urandom % 4);
      ctx_id = $urandom; bp_hit = NBP'($urandom); wp_hit = NWP'($urandom);
      for (int i = 0; i < NBP; i++) begin
        bp_ctl[i] = $urandom & 32'h00FF_E007;
        if ($urandom % 2) bp_ctl[i][23:20] = 4'd3;
        if ($urandom % 2) bp_ctl[i][20] = 1'b0;
        bp_val[i] = ($urandom % 2) ? ctx_id : $urandom;
      end
      for (int i = 0; i < NWP; i++) wp_ctl[i] = $urandom & 32'h001F_E007;
      step("R7 random", -1);
    end

    req_valid = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule